// File: doc/BRIEF.md
# Event Acceptance Logic for a Four-Input Pulse Digitizer

This block decides, for each of several analog input channels, whether a detected pulse peak is taken for conversion. Each channel provides a one-cycle peak strobe. At that instant the block samples three conditions. The first is the channel's own gate level, which can be ignored per channel. The second is a master gate, formed as the OR of two gate sources, which can be ignored globally. The third is the channel's pile-up veto. A global inhibit and a common clear also act on the decision.

Two acquisition modes exist. In coincidence mode, the first accepted event arms a lock. Every channel then refuses new peaks until the shared clear arrives, so all modules in a system can be released together. In singles mode there is no lock: each channel stays busy after its own acceptance, and it re-arms when its result has been read out, which is signalled by a per-channel done pulse.

Each acceptance produces a one-cycle accept pulse and a stretched indicator pulse on that channel. A busy flag per channel and the lock state are exported.

Top module: `evt_accept`

## Requirements
- R1: A channel's peak is accepted only if its gate input is high, or if its gate-ignore bit is 1. In that case the gate level has no effect.
- R2: A peak is accepted only if at least one of the two master gate inputs is high, or if the master-gate-ignore bit is 1.
- R3: A peak on a channel whose pile-up veto input is high at the strobe cycle is rejected.
- R4: Gate, veto and mode levels are sampled in the cycle where the peak strobe is high. An accepted peak raises accept_o for that channel for exactly one cycle, in the cycle after the strobe. accept_o is never high without a qualifying strobe.
- R5: In coincidence mode (singles_i = 0), all channels qualifying in the same cycle are accepted together. Any acceptance sets locked_o. While locked_o is high, no peak on any channel is accepted.
- R6: A clear_i pulse drops every busy flag and locked_o at the next edge. A peak strobe in the same cycle as clear_i is not accepted.
- R7: While inhibit_i is high, no new peak is accepted. Busy flags and lock already set are kept.
- R8: In singles mode (singles_i = 1), acceptance never sets locked_o. A done_i pulse on a channel drops only that channel's busy flag, and the channel can then accept again.
- R9: busy_o for a channel rises with its acceptance. A peak strobe on a busy channel is ignored. After reset, busy_o, locked_o, accept_o and blink_o are all 0.
- R10: Each acceptance drives blink_o for that channel high for exactly BLINK_CYC cycles (default 4). The blink starts in the cycle after accept_o.
- R11: In coincidence mode, done_i has no effect. Busy flags are released only by clear_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| peak_i | input | NCH | Per-channel peak-detect strobe, one cycle |
| gate_i | input | NCH | Per-channel gate level, 1 permits |
| veto_i | input | NCH | Per-channel pile-up veto, 1 rejects |
| gate_ign_i | input | NCH | Per-channel gate ignore, 1 ignores gate_i |
| mgate_a_i | input | 1 | Master gate source A |
| mgate_b_i | input | 1 | Master gate source B |
| mgate_ign_i | input | 1 | 1 ignores the master gate |
| singles_i | input | 1 | 0 coincidence mode, 1 singles mode |
| inhibit_i | input | 1 | Blocks new acceptances |
| clear_i | input | 1 | Common clear of busy flags and lock |
| done_i | input | NCH | Per-channel readout done, re-arms in singles mode |
| accept_o | output | NCH | One-cycle accept pulse per channel |
| blink_o | output | NCH | Stretched indicator pulse per channel |
| busy_o | output | NCH | Channel holds an accepted event |
| locked_o | output | 1 | Coincidence lockout active |

## Verification
The assertions watch several rules on every cycle:
- no acceptance on a channel that was busy, vetoed or inhibited in the previous cycle;
- the lock holds until a clear, and is present after any coincidence acceptance;
- a busy flag falls only on a clear, or on a done in singles mode;
- every accept is followed by a blink.

Only the bench scenarios can show the remaining behaviour:
- the gate-ignore and master-gate combinations;
- independent re-arming per channel in singles mode;
- done having no effect in coincidence mode;
- the clear-versus-strobe collision;
- the exact blink length.

// File: rtl/evt_accept_pkg.sv
package evt_accept_pkg;
  typedef enum logic {
    MODE_COINC   = 1'b0,
    MODE_SINGLES = 1'b1
  } acq_mode_e;
endpackage

// File: rtl/evt_qualify.sv
module evt_qualify #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] peak_i,
  input  logic [NCH-1:0] gate_i,
  input  logic [NCH-1:0] veto_i,
  input  logic [NCH-1:0] gate_ign_i,
  input  logic [NCH-1:0] busy_i,
  input  logic           mgate_a_i,
  input  logic           mgate_b_i,
  input  logic           mgate_ign_i,
  input  logic           inhibit_i,
  input  logic           clear_i,
  input  logic           lock_i,
  output logic [NCH-1:0] hit_o
);
  logic master_open;
  logic global_open;

  assign master_open = mgate_ign_i | mgate_a_i | mgate_b_i;
  assign global_open = master_open & ~inhibit_i & ~clear_i & ~lock_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic ch_open;
    assign ch_open  = (gate_ign_i[c] | gate_i[c]) & ~veto_i[c] & ~busy_i[c];
    assign hit_o[c] = peak_i[c] & ch_open & global_open;
  end
endmodule

// File: rtl/evt_arm_ctrl.sv
module evt_arm_ctrl
  import evt_accept_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] hit_i,
  input  acq_mode_e      mode_i,
  input  logic           clear_i,
  input  logic [NCH-1:0] done_i,
  output logic [NCH-1:0] accept_o,
  output logic [NCH-1:0] busy_o,
  output logic           lock_o
);
  logic [NCH-1:0] busy_q, busy_d, rearm;
  logic [NCH-1:0] accept_q;
  logic           lock_q, lock_d;

  assign rearm = (mode_i == MODE_SINGLES) ? done_i : '0;

  always_comb begin
    busy_d = busy_q;
    lock_d = lock_q;
    if (clear_i) begin
      busy_d = '0;
      lock_d = 1'b0;
    end else begin
      busy_d = (busy_q & ~rearm) | hit_i;
      if (mode_i == MODE_COINC && |hit_i) lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= '0;
      lock_q   <= 1'b0;
      accept_q <= '0;
    end else begin
      busy_q   <= busy_d;
      lock_q   <= lock_d;
      accept_q <= hit_i;
    end
  end

  assign accept_o = accept_q;
  assign busy_o   = busy_q;
  assign lock_o   = lock_q;

  // R9
  no_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_q & $past(busy_q)) == '0);
  // R5
  coinc_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_q != '0 && $past(mode_i) == MODE_COINC) |-> lock_q);
  // R5
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !clear_i) |=> lock_q);
  // R6
  clear_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (busy_q == '0 && !lock_q));
  // R11
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_q) & ~busy_q & ~({NCH{$past(clear_i)}} |
      ($past(done_i) & {NCH{$past(mode_i) == MODE_SINGLES}}))) == '0);
endmodule

// File: rtl/evt_blink.sv
module evt_blink #(
  parameter int NCH       = 4,
  parameter int BLINK_CYC = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] accept_i,
  output logic [NCH-1:0] blink_o
);
  localparam int BW = $clog2(BLINK_CYC + 1);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [BW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cnt_q <= '0;
      else if (accept_i[c]) cnt_q <= BW'(BLINK_CYC);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
    assign blink_o[c] = (cnt_q != '0);
  end

  // R10
  blink_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i != '0) |=> ((blink_o & $past(accept_i)) == $past(accept_i)));
endmodule

// File: rtl/evt_accept.sv
module evt_accept
  import evt_accept_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int BLINK_CYC = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] peak_i,
  input  logic [NCH-1:0] gate_i,
  input  logic [NCH-1:0] veto_i,
  input  logic [NCH-1:0] gate_ign_i,
  input  logic           mgate_a_i,
  input  logic           mgate_b_i,
  input  logic           mgate_ign_i,
  input  logic           singles_i,
  input  logic           inhibit_i,
  input  logic           clear_i,
  input  logic [NCH-1:0] done_i,
  output logic [NCH-1:0] accept_o,
  output logic [NCH-1:0] blink_o,
  output logic [NCH-1:0] busy_o,
  output logic           locked_o
);
  logic [NCH-1:0] hit;
  logic [NCH-1:0] busy;
  logic [NCH-1:0] accept;
  logic           lock;
  acq_mode_e      mode;

  assign mode = singles_i ? MODE_SINGLES : MODE_COINC;

  evt_qualify #(.NCH(NCH)) u_qual (
    .peak_i      (peak_i),
    .gate_i      (gate_i),
    .veto_i      (veto_i),
    .gate_ign_i  (gate_ign_i),
    .busy_i      (busy),
    .mgate_a_i   (mgate_a_i),
    .mgate_b_i   (mgate_b_i),
    .mgate_ign_i (mgate_ign_i),
    .inhibit_i   (inhibit_i),
    .clear_i     (clear_i),
    .lock_i      (lock),
    .hit_o       (hit)
  );

  evt_arm_ctrl #(.NCH(NCH)) u_arm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .mode_i   (mode),
    .clear_i  (clear_i),
    .done_i   (done_i),
    .accept_o (accept),
    .busy_o   (busy),
    .lock_o   (lock)
  );

  evt_blink #(.NCH(NCH), .BLINK_CYC(BLINK_CYC)) u_blink (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .blink_o  (blink_o)
  );

  assign accept_o = accept;
  assign busy_o   = busy;
  assign locked_o = lock;

  // R3
  veto_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept & $past(veto_i)) == '0);
  // R7
  inhibit_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(inhibit_i) |-> (accept == '0));
  // R4
  strobe_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept & ~$past(peak_i)) == '0);
endmodule

// File: tb/sim_evt_accept.sv
module sim_evt_accept;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int BLINK_CYC  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] peak = '0, gate = '1, veto = '0, gate_ign = '0, done = '0;
  logic mg_a = 1'b1, mg_b = 1'b0, mg_ign = 1'b0, singles = 1'b0, inhibit = 1'b0, clear = 1'b0;
  logic [NCH-1:0] accept, blink, busy;
  logic locked;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    int             cyc;
    logic [NCH-1:0] mask;
    string          rq;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  evt_accept #(.NCH(NCH), .BLINK_CYC(BLINK_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .peak_i(peak), .gate_i(gate), .veto_i(veto),
    .gate_ign_i(gate_ign), .mgate_a_i(mg_a), .mgate_b_i(mg_b), .mgate_ign_i(mg_ign),
    .singles_i(singles), .inhibit_i(inhibit), .clear_i(clear), .done_i(done),
    .accept_o(accept), .blink_o(blink), .busy_o(busy), .locked_o(locked)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // monitor: compares accept_o against scoreboard a quarter cycle after each edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_n) begin
      if (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.rq, 32'(accept), 32'(e.mask));
      end else if (accept != '0) begin
        chk("R4 unexpected accept", 32'(accept), 32'h0);
      end
    end
  end

  // driver: one-cycle strobe (optionally with clear), expectation pushed for next edge
  task automatic strobe(input logic [NCH-1:0] m, input logic clr,
                        input logic [NCH-1:0] exp, input string rq);
    exp_t e;
    @(negedge clk);
    peak  = m;
    clear = clr;
    e.cyc = cyc + 1; e.mask = exp; e.rq = rq;
    sb_q.push_back(e);
    @(negedge clk);
    peak  = '0;
    clear = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic do_done(input logic [NCH-1:0] m);
    @(negedge clk); done = m;
    @(negedge clk); done = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset busy", 32'(busy), 0);
    chk("R9 reset locked", 32'(locked), 0);
    chk("R9 reset blink", 32'(blink), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 coincidence: simultaneous hits accepted together, lock set
    strobe(4'b0101, 1'b0, 4'b0101, "R5 coincident pair");
    chk("R5 locked", 32'(locked), 1);
    chk("R9 busy after accept", 32'(busy), 32'h5);
    strobe(4'b0010, 1'b0, 4'b0000, "R5 locked blocks");
    strobe(4'b0001, 1'b0, 4'b0000, "R9 busy ignores strobe");
    do_clear();
    chk("R6 clear busy", 32'(busy), 0);
    chk("R6 clear lock", 32'(locked), 0);

    // R1 per-channel gate and its ignore bit
    gate[1] = 1'b0;
    strobe(4'b0010, 1'b0, 4'b0000, "R1 gate low blocks");
    gate_ign[1] = 1'b1;
    strobe(4'b0010, 1'b0, 4'b0010, "R1 gate ignored");
    gate[1] = 1'b1; gate_ign[1] = 1'b0;
    do_clear();

    // R2 master gate OR and ignore
    mg_a = 1'b0; mg_b = 1'b0;
    strobe(4'b0001, 1'b0, 4'b0000, "R2 master closed");
    mg_b = 1'b1;
    strobe(4'b0001, 1'b0, 4'b0001, "R2 master source B");
    do_clear();
    mg_b = 1'b0; mg_ign = 1'b1;
    strobe(4'b1000, 1'b0, 4'b1000, "R2 master ignored");
    do_clear();
    mg_ign = 1'b0; mg_a = 1'b1;

    // R3 veto
    veto[3] = 1'b1;
    strobe(4'b1000, 1'b0, 4'b0000, "R3 veto rejects");
    veto[3] = 1'b0;
    strobe(4'b1000, 1'b0, 4'b1000, "R3 veto released");
    do_clear();

    // R7 inhibit blocks new but keeps busy
    strobe(4'b0001, 1'b0, 4'b0001, "R7 pre-inhibit accept");
    inhibit = 1'b1;
    @(negedge clk);
    chk("R7 busy kept", 32'(busy), 32'h1);
    chk("R7 lock kept", 32'(locked), 1);
    do_clear();
    strobe(4'b0100, 1'b0, 4'b0000, "R7 inhibit blocks");
    inhibit = 1'b0;

    // R6 clear colliding with strobe
    strobe(4'b0100, 1'b1, 4'b0000, "R6 clear vs strobe");
    chk("R6 nothing busy", 32'(busy), 0);

    // R8 singles mode
    singles = 1'b1;
    strobe(4'b0001, 1'b0, 4'b0001, "R8 singles ch0");
    chk("R8 no lock", 32'(locked), 0);
    strobe(4'b0010, 1'b0, 4'b0010, "R8 singles ch1 independent");
    strobe(4'b0001, 1'b0, 4'b0000, "R9 singles busy ignores");
    do_done(4'b0001);
    chk("R8 done rearms only ch0", 32'(busy), 32'h2);
    strobe(4'b0001, 1'b0, 4'b0001, "R8 ch0 rearmed");
    do_clear();

    // R11 coincidence: done has no effect
    singles = 1'b0;
    strobe(4'b0100, 1'b0, 4'b0100, "R11 coinc accept");
    do_done(4'b0100);
    chk("R11 busy held", 32'(busy), 32'h4);
    chk("R11 lock held", 32'(locked), 1);
    do_clear();

    // R10 blink length
    repeat (BLINK_CYC + 2) @(negedge clk);
    strobe(4'b0010, 1'b0, 4'b0010, "R10 blink source");
    chk("R10 blink not before accept", 32'(blink[1]), 0);
    begin
      int hi = 0;
      for (int i = 0; i < BLINK_CYC + 4; i++) begin
        @(negedge clk);
        if (blink[1]) hi++;
      end
      chk("R10 blink cycles", 32'(hi), 32'(BLINK_CYC));
    end
    do_clear();

    repeat (3) @(negedge clk);
    chk("R4 scoreboard drained", 32'(sb_q.size()), 0);
    finish_run();
  end
endmodule